// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a downstream port that supports hot-plug. Software reaches both registers through a small word-wide register port with byte enables: one address bit selects control or status, and reads return the selected register without a cycle of delay. The slot hardware side reports two kinds of event, an attention button press and the arrival of a device. Every write to slot control is treated as one command that completes at once. Writing 1 to the interlock control bit flips the interlock status. A write that sets the power controller off while the power indicator is off starts a detach of a present device.

The block works out an interrupt-pending condition from the enabled event bits. A mode input selects how it reports. In message mode, a one-cycle trigger marks every change of the pending condition. In level mode, an interrupt output follows the pending condition. Message formatting and config-space routing are handled outside the block.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, control reads 0x00C0 (attention indicator [7:6] = 11, meaning off). Status reads 0x0000. `irq_level`, `msg_pulse` and `detach_pulse` are 0.
- R2: A control write (`reg_addr`=0) updates only the writable control bits in the enabled byte lanes. The writable bits are attention button enable (bit 0), presence-changed enable (bit 3), command-completed enable (bit 4), hot-plug interrupt enable (bit 5), attention indicator [7:6], power indicator [9:8] and power controller control (bit 10). All other bits read 0. A write with no byte enable changes nothing.
- R3: Every control write with at least one byte enable sets command completed (status bit 4) at the clock edge of that write, whichever fields the write changes.
- R4: Interlock control (control bit 11) always reads 0. Writing 1 to it with the upper byte lane enabled toggles interlock status (status bit 7).
- R5: A control write detaches the device when presence state (status bit 6) is 1 and the merged value being written has power controller bit 10 = 1 and power indicator [9:8] = 11. The detach clears bit 6, sets presence changed (bit 3), and gives `detach_pulse` high for one cycle. If the indicator holds any other code, nothing is detached.
- R6: `btn_press` sets attention button (status bit 0). `dev_arrive` sets status bits 6, 3 and 0.
- R7: A status write (`reg_addr`=1) with the lower lane enabled clears each of status bits 0, 3 and 4 that is written as 1. Bits 6 and 7 are not affected by status writes.
- R8: The pending condition is control bit 5 AND (status AND control AND 0x0019) being nonzero.
- R9: With `msg_mode`=0, `irq_level` equals the pending condition of the current register contents. It falls as soon as a status write clears the last enabled event.
- R10: With `msg_mode`=1, `msg_pulse` is high for exactly one cycle after each register update in which the pending condition changes value, rising or falling. In this mode `irq_level` stays 0.
- R11: Raising an event whose status bit is already set produces no new `msg_pulse`.
- R12: When an event input and a status clear of the same bit fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects slot control, 1 selects slot status |
| reg_be | input | 2 | Byte enables of the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| btn_press | input | 1 | Attention button event, one cycle |
| dev_arrive | input | 1 | Device arrival event, one cycle |
| msg_mode | input | 1 | 1 selects message trigger, 0 selects level interrupt |
| irq_level | output | 1 | Level interrupt request |
| msg_pulse | output | 1 | One-cycle message trigger |
| detach_pulse | output | 1 | One-cycle request to detach the slot device |

## Verification
The assertions assume three things about the inputs. Event inputs are single-cycle strobes. A write carries exactly one address. `msg_mode` changes only between register updates, never in the middle of an observed transition. The stimulus meets these conditions in three ways. It drives every input at the falling edge and holds it through exactly one rising edge. It clears strobes straight after that edge. It changes the mode only on a vector boundary where the pending condition is already settled.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
  localparam int REG_W  = 16;
  localparam int LANE_W = 8;

  // status bit positions
  localparam int ST_ABP = 0;
  localparam int ST_PDC = 3;
  localparam int ST_CC  = 4;
  localparam int ST_PDS = 6;
  localparam int ST_ILK = 7;

  // control bit positions
  localparam int CT_HPIE = 5;
  localparam int CT_AI_LO = 6;
  localparam int CT_PI_LO = 8;
  localparam int CT_PCC  = 10;
  localparam int CT_ILKC = 11;

  localparam logic [1:0] IND_OFF = 2'b11;

  localparam logic [REG_W-1:0] CTL_WMASK = 16'h07F9;
  localparam logic [REG_W-1:0] EVT_MASK  = 16'h0019;
  localparam logic [REG_W-1:0] CTL_RST   = 16'h00C0;

  function automatic logic [REG_W-1:0] lane_merge(
    input logic [REG_W-1:0]        old_v,
    input logic [REG_W-1:0]        new_v,
    input logic [REG_W/LANE_W-1:0] be
  );
    logic [REG_W-1:0] r;
    r = old_v;
    for (int i = 0; i < REG_W/LANE_W; i++) begin
      if (be[i]) r[i*LANE_W +: LANE_W] = new_v[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  function automatic logic pending_of(
    input logic [REG_W-1:0] ctl,
    input logic [REG_W-1:0] stat
  );
    return ctl[CT_HPIE] & (|(stat & ctl & EVT_MASK));
  endfunction
endpackage

// File: rtl/hp_ctl_reg.sv
module hp_ctl_reg
  import hp_slot_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_wr,
  input  logic [W-1:0]          wdata,
  input  logic [W/LANE_W-1:0]   be,
  output logic [W-1:0]          ctl_q,
  output logic [W-1:0]          ctl_nxt,
  output logic                  cmd_evt,
  output logic                  ilk_toggle,
  output logic                  power_off_req
);
  localparam int BE_W = W / LANE_W;
  localparam int HI_LANE = CT_ILKC / LANE_W;

  logic [W-1:0] merged;

  assign merged  = lane_merge(ctl_q, wdata, be);
  assign cmd_evt = ctl_wr & (|be);
  assign ilk_toggle = cmd_evt & be[HI_LANE] & wdata[CT_ILKC];
  assign power_off_req = cmd_evt & merged[CT_PCC] &
                         (merged[CT_PI_LO +: 2] == IND_OFF);

  always_comb begin
    ctl_nxt = ctl_q;
    if (cmd_evt) ctl_nxt = merged & CTL_WMASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= CTL_RST;
    else        ctl_q <= ctl_nxt;
  end

  logic unused_be;
  assign unused_be = ^be[BE_W-1:0];
endmodule

// File: rtl/hp_stat_reg.sv
module hp_stat_reg
  import hp_slot_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stat_wr,
  input  logic [W-1:0]          wdata,
  input  logic [W/LANE_W-1:0]   be,
  input  logic                  cmd_evt,
  input  logic                  ilk_toggle,
  input  logic                  power_off_req,
  input  logic                  btn_press,
  input  logic                  dev_arrive,
  output logic [W-1:0]          stat_q,
  output logic [W-1:0]          stat_nxt,
  output logic                  detach_q
);
  logic detach_evt;
  logic [W-1:0] clr_mask;

  assign detach_evt = power_off_req & stat_q[ST_PDS];
  assign clr_mask   = (stat_wr & be[0]) ? (wdata & EVT_MASK) : '0;

  always_comb begin
    stat_nxt = stat_q & ~clr_mask;
    if (ilk_toggle) stat_nxt[ST_ILK] = ~stat_q[ST_ILK];
    if (detach_evt) begin
      stat_nxt[ST_PDS] = 1'b0;
      stat_nxt[ST_PDC] = 1'b1;
    end
    if (cmd_evt)   stat_nxt[ST_CC]  = 1'b1;
    if (btn_press) stat_nxt[ST_ABP] = 1'b1;
    if (dev_arrive) begin
      stat_nxt[ST_PDS] = 1'b1;
      stat_nxt[ST_PDC] = 1'b1;
      stat_nxt[ST_ABP] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q   <= '0;
      detach_q <= 1'b0;
    end else begin
      stat_q   <= stat_nxt;
      detach_q <= detach_evt;
    end
  end
endmodule

// File: rtl/hp_notify.sv
module hp_notify
  import hp_slot_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ctl_nxt,
  input  logic [W-1:0] stat_nxt,
  input  logic         msg_mode,
  output logic         pending_q,
  output logic         irq_q,
  output logic         msg_q
);
  logic pending_nxt;

  assign pending_nxt = pending_of(ctl_nxt, stat_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      irq_q     <= 1'b0;
      msg_q     <= 1'b0;
    end else begin
      pending_q <= pending_nxt;
      irq_q     <= ~msg_mode & pending_nxt;
      msg_q     <= msg_mode & (pending_nxt != pending_q);
    end
  end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
  import hp_slot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [1:0]  reg_be,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        btn_press,
  input  logic        dev_arrive,
  input  logic        msg_mode,
  output logic        irq_level,
  output logic        msg_pulse,
  output logic        detach_pulse
);
  logic [REG_W-1:0] ctl_q, ctl_nxt, stat_q, stat_nxt;
  logic cmd_evt, ilk_toggle, power_off_req, pending_q;
  logic ctl_wr, stat_wr;

  assign ctl_wr  = reg_wr & ~reg_addr;
  assign stat_wr = reg_wr &  reg_addr;

  hp_ctl_reg #(.W(REG_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(reg_wdata), .be(reg_be),
    .ctl_q(ctl_q), .ctl_nxt(ctl_nxt), .cmd_evt(cmd_evt),
    .ilk_toggle(ilk_toggle), .power_off_req(power_off_req)
  );

  hp_stat_reg #(.W(REG_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .wdata(reg_wdata), .be(reg_be),
    .cmd_evt(cmd_evt), .ilk_toggle(ilk_toggle), .power_off_req(power_off_req),
    .btn_press(btn_press), .dev_arrive(dev_arrive),
    .stat_q(stat_q), .stat_nxt(stat_nxt), .detach_q(detach_pulse)
  );

  hp_notify #(.W(REG_W)) u_ntf (
    .clk(clk), .rst_n(rst_n), .ctl_nxt(ctl_nxt), .stat_nxt(stat_nxt),
    .msg_mode(msg_mode), .pending_q(pending_q), .irq_q(irq_level),
    .msg_q(msg_pulse)
  );

  assign reg_rdata = reg_addr ? stat_q : ctl_q;
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_addr,
  input logic [1:0]  reg_be,
  input logic [15:0] reg_wdata,
  input logic        btn_press,
  input logic        dev_arrive,
  input logic        irq_level,
  input logic        msg_pulse,
  input logic        detach_pulse,
  input logic [15:0] stat_q,
  input logic        pending_q
);
  AST_CMD_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && (|reg_be)) |=> stat_q[4]); // R3

  AST_ILK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_be[1] && reg_wdata[11]) |=> (stat_q[7] != $past(stat_q[7]))); // R4

  AST_DETACH_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    detach_pulse |-> (stat_q[3] && $past(stat_q[6]))); // R5

  AST_BTN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    btn_press |=> stat_q[0]); // R6

  AST_ARRIVAL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_arrive |=> (stat_q[6] && stat_q[3] && stat_q[0])); // R6

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level |-> pending_q); // R9

  AST_MSG_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse |-> (pending_q != $past(pending_q))); // R10

  AST_MSG_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse |-> !irq_level); // R10
endmodule

bind hp_slot_ctrl hp_slot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_be(reg_be), .reg_wdata(reg_wdata), .btn_press(btn_press),
  .dev_arrive(dev_arrive), .irq_level(irq_level), .msg_pulse(msg_pulse),
  .detach_pulse(detach_pulse), .stat_q(stat_q), .pending_q(pending_q)
);

// File: tb/hp_slot_ctrl_bench.sv
`timescale 1ns/100ps
module hp_slot_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [1:0] reg_be = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic btn_press = 1'b0, dev_arrive = 1'b0, msg_mode = 1'b0;
  logic irq_level, msg_pulse, detach_pulse;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hp_slot_ctrl u_hp_slot_ctrl (.*);

  // fields: wr addr be wdata btn arr msg | ctl stat irq msg det
  function automatic logic [57:0] vec(
    input logic wr, input logic ad, input logic [1:0] be, input logic [15:0] wd,
    input logic bt, input logic ar, input logic mm,
    input logic [15:0] ec, input logic [15:0] es,
    input logic ei, input logic em, input logic ed);
    return {wr, ad, be, wd, bt, ar, mm, ec, es, ei, em, ed};
  endfunction

  localparam int NV = 25;
  localparam logic [57:0] VEC [NV] = '{
    vec(0,0,2'b00,16'h0000,0,1,0, 16'h00C0,16'h0049,0,0,0), // 0 R6 arrival
    vec(1,0,2'b11,16'h0039,0,0,0, 16'h0039,16'h0059,1,0,0), // 1 R2 R3 R8 R9
    vec(1,1,2'b01,16'h0019,0,0,0, 16'h0039,16'h0040,0,0,0), // 2 R7 R9
    vec(0,0,2'b00,16'h0000,1,0,0, 16'h0039,16'h0041,1,0,0), // 3 R6
    vec(0,0,2'b00,16'h0000,1,0,0, 16'h0039,16'h0041,1,0,0), // 4 R11
    vec(1,1,2'b01,16'h0001,1,0,0, 16'h0039,16'h0041,1,0,0), // 5 R12
    vec(1,1,2'b11,16'hFFC1,0,0,0, 16'h0039,16'h0040,0,0,0), // 6 R7 bits 6,7 kept
    vec(1,0,2'b10,16'h0800,0,0,0, 16'h0039,16'h00D0,1,0,0), // 7 R4
    vec(1,1,2'b01,16'h0010,0,0,0, 16'h0039,16'h00C0,0,0,0), // 8 R7
    vec(1,0,2'b10,16'h0800,0,0,0, 16'h0039,16'h0050,1,0,0), // 9 R4
    vec(1,0,2'b01,16'h00FF,0,0,0, 16'h00F9,16'h0050,1,0,0), // 10 R2
    vec(1,0,2'b11,16'h0739,0,0,0, 16'h0739,16'h0018,1,0,1), // 11 R5
    vec(1,1,2'b01,16'h0018,0,0,0, 16'h0739,16'h0000,0,0,0), // 12 R7
    vec(1,0,2'b11,16'h0700,0,0,0, 16'h0700,16'h0010,0,0,0), // 13 R5 absent
    vec(1,0,2'b11,16'h0039,0,0,1, 16'h0039,16'h0010,0,1,0), // 14 R10
    vec(0,0,2'b00,16'h0000,1,0,1, 16'h0039,16'h0011,0,0,0), // 15 R11
    vec(1,1,2'b01,16'h0011,0,0,1, 16'h0039,16'h0000,0,1,0), // 16 R10 falling
    vec(0,0,2'b00,16'h0000,0,0,1, 16'h0039,16'h0000,0,0,0), // 17 R10
    vec(0,0,2'b00,16'h0000,1,0,1, 16'h0039,16'h0001,0,1,0), // 18 R10
    vec(0,0,2'b00,16'h0000,1,0,1, 16'h0039,16'h0001,0,0,0), // 19 R11
    vec(0,0,2'b00,16'h0000,0,0,0, 16'h0039,16'h0001,1,0,0), // 20 R9
    vec(0,0,2'b00,16'h0000,0,1,0, 16'h0039,16'h0049,1,0,0), // 21 R6
    vec(1,0,2'b11,16'h0639,0,0,0, 16'h0639,16'h0059,1,0,0), // 22 R5 blink
    vec(1,1,2'b01,16'h0019,0,0,0, 16'h0639,16'h0040,0,0,0), // 23 R9
    vec(1,0,2'b00,16'hFFFF,0,0,0, 16'h0639,16'h0040,0,0,0)  // 24 R2 R3 no lane
  };
  localparam string TAG [NV] = '{
    "R6","R3","R7","R6","R11","R12","R7","R4","R7","R4","R2","R5","R7",
    "R5","R10","R11","R10","R10","R10","R11","R9","R6","R5","R9","R2"};

  task automatic read_regs(output logic [15:0] c, output logic [15:0] s);
    reg_addr = 1'b0; #0.5; c = reg_rdata;
    reg_addr = 1'b1; #0.5; s = reg_rdata;
  endtask

  task automatic compare(input string tag, input logic [15:0] c, input logic [15:0] s,
                         input logic [15:0] ec, input logic [15:0] es,
                         input logic ei, input logic em, input logic ed);
    n_chk++;
    if (c !== ec || s !== es || irq_level !== ei || msg_pulse !== em || detach_pulse !== ed) begin
      n_bad++;
      $display("FAIL %s: ctl=%h stat=%h irq=%b msg=%b det=%b expected ctl=%h stat=%h irq=%b msg=%b det=%b",
               tag, c, s, irq_level, msg_pulse, detach_pulse, ec, es, ei, em, ed);
    end
  endtask

  initial begin
    logic [15:0] c, s;
    repeat (3) @(negedge clk);
    read_regs(c, s);
    compare("R1 reset", c, s, 16'h00C0, 16'h0000, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {reg_wr, reg_addr, reg_be, reg_wdata, btn_press, dev_arrive, msg_mode} = VEC[i][57:35];
      @(posedge clk); #1;
      reg_wr = 1'b0; btn_press = 1'b0; dev_arrive = 1'b0;
      @(negedge clk);
      read_regs(c, s);
      compare(TAG[i], c, s, VEC[i][34:19], VEC[i][18:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end
    // R1: reset in the middle of activity restores the reset state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    read_regs(c, s);
    compare("R1 mid-run reset", c, s, 16'h00C0, 16'h0000, 1'b0, 1'b0, 1'b0);
    // R4: after reset, interlock write with lower lane only does not toggle
    rst_n = 1'b1;
    @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b0; reg_be = 2'b01; reg_wdata = 16'h0800;
    @(posedge clk); #1; reg_wr = 1'b0;
    @(negedge clk);
    read_regs(c, s);
    compare("R4 lower lane", c, s, 16'h0000, 16'h0010, 1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule